// File: doc/BRIEF.md
# Delay-Line Phase Calibration Controller

This block runs the calibration of a tapped clock delay line whose output phase clocks incoming receive data. On a start request it switches on the line and the line's length sampler. It then walks the unit-delay code upward from zero, one code per trial. Each trial ends with a look at the sampled length vector, and the walk stops at the first code whose vector shows one usable clock period along the line.

From the highest active bit of the accepted vector the controller derives an output phase tap. It programs that tap, switches the sampler off and leaves the line running. If no code fits, or if the accepted vector has no usable span, every control to the line drops to zero and an error pulse is raised. A disable request turns the line off at any moment.

The settling wait after each new setting is a parameterised number of clock cycles. It stands in for a millisecond-scale wait. The analog delay elements sit outside the block.

Top module: `dly_cal_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, busy, done, error, line enable, sampler enable, unit code and phase select are all zero.
- R2: A start request seen while idle sets busy, line enable and sampler enable on the next cycle, with unit code 0 and phase select 12.
- R3: Each trial holds its setting for SETTLE_CYC cycles plus one judging cycle. The result of trial k therefore appears (k+1)*(SETTLE_CYC+1) cycles after the start edge. A rejected trial raises the unit code by exactly one and keeps phase select at 12.
- R4: A trial is accepted only when the length-valid input is 1, the 12-bit length vector is non-zero, and the vector is not 12'hC00 (only bits 11 and 10 set).
- R5: On acceptance, N is the index of the highest set bit of the vector among bits 10 down to 1. Phase select becomes N/2+1 using integer division.
- R6: A successful calibration gives a one-cycle done pulse and drops busy. It clears sampler enable, keeps line enable at 1 and holds the accepted unit code.
- R7: If the accepted vector has none of bits 10..1 set (N = 0), the block gives a one-cycle error pulse, drops busy and clears every control output to zero.
- R8: If all MAX_TRIALS codes (0..127) are rejected, the block gives a one-cycle error pulse and clears every control output to zero.
- R9: A disable request clears busy and every control output on the next cycle, with no done or error pulse. It takes priority over start.
- R10: A start request while busy has no effect on the ongoing sweep or on its result timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration start request |
| disable_i | input | 1 | Turn the line off and abort |
| len_vec_i | input | 12 | Sampled line-length vector |
| len_valid_i | input | 1 | Length vector valid flag |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | One-cycle failure pulse |
| line_en_o | output | 1 | Delay line enable |
| samp_en_o | output | 1 | Length sampler enable |
| unit_code_o | output | 7 | Unit-delay code |
| phase_sel_o | output | 4 | Output phase select |

## Verification
All outputs are registered, so the response to start or disable shows exactly one cycle after the edge that samples the request. A trial's verdict lands (k+1)*(SETTLE_CYC+1) cycles after the start edge. The directed tasks count that many edges from the start edge. They check that busy is still high and done/error are still low one cycle before the verdict, then check the verdict at the due cycle, and check the next cycle to confirm the pulse lasts one cycle. Every sample is taken on the falling clock edge, away from the edge at which the design updates.

// File: rtl/dly_cal_pkg.sv
package dly_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_JUDGE  = 2'd2
  } cal_state_t;
endpackage

// File: rtl/dly_cal_settle.sv
// Settling timer: counts while run is high, flags the last settle cycle.
module dly_cal_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/dly_cal_judge.sv
// Trial verdict: acceptance rule, highest span bit, derived phase tap.
module dly_cal_judge #(
  parameter int LEN_W = 12,
  parameter int SEL_W = 4
) (
  input  logic [LEN_W-1:0] len_vec,
  input  logic             len_valid,
  output logic             accept,
  output logic             span_ok,
  output logic [SEL_W-1:0] phase
);
  localparam int IDX_W = $clog2(LEN_W);
  localparam logic [LEN_W-1:0] EDGE_ONLY = {2'b11, {(LEN_W-2){1'b0}}};

  logic [IDX_W-1:0] top_idx;

  assign accept = len_valid && (len_vec != '0) && (len_vec != EDGE_ONLY);

  always_comb begin
    top_idx = '0;
    for (int b = 1; b <= LEN_W - 2; b++) begin
      if (len_vec[b]) top_idx = IDX_W'(b);
    end
  end

  assign span_ok = (top_idx != '0);
  assign phase   = SEL_W'((top_idx >> 1) + 1);
endmodule

// File: rtl/dly_cal_ctrl.sv
module dly_cal_ctrl #(
  parameter int LEN_W      = 12,
  parameter int CODE_W     = 7,
  parameter int SEL_W      = 4,
  parameter int MAX_TRIALS = 128,
  parameter int PROBE_SEL  = 12,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              disable_i,
  input  logic [LEN_W-1:0]  len_vec_i,
  input  logic              len_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              line_en_o,
  output logic              samp_en_o,
  output logic [CODE_W-1:0] unit_code_o,
  output logic [SEL_W-1:0]  phase_sel_o
);
  import dly_cal_pkg::*;

  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(MAX_TRIALS - 1);
  localparam logic [SEL_W-1:0]  PROBE     = SEL_W'(PROBE_SEL);

  cal_state_t       state;
  logic             settle_exp;
  logic             accept, span_ok;
  logic [SEL_W-1:0] tap;

  dly_cal_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .run    (state == ST_SETTLE),
    .expire (settle_exp)
  );

  dly_cal_judge #(.LEN_W(LEN_W), .SEL_W(SEL_W)) u_judge (
    .len_vec   (len_vec_i),
    .len_valid (len_valid_i),
    .accept    (accept),
    .span_ok   (span_ok),
    .phase     (tap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      error_o     <= 1'b0;
      line_en_o   <= 1'b0;
      samp_en_o   <= 1'b0;
      unit_code_o <= '0;
      phase_sel_o <= '0;
    end else begin
      done_o  <= 1'b0;
      error_o <= 1'b0;
      if (disable_i) begin
        state       <= ST_IDLE;
        busy_o      <= 1'b0;
        line_en_o   <= 1'b0;
        samp_en_o   <= 1'b0;
        unit_code_o <= '0;
        phase_sel_o <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start_i) begin
              state       <= ST_SETTLE;
              busy_o      <= 1'b1;
              line_en_o   <= 1'b1;
              samp_en_o   <= 1'b1;
              unit_code_o <= '0;
              phase_sel_o <= PROBE;
            end
          end
          ST_SETTLE: begin
            if (settle_exp) state <= ST_JUDGE;
          end
          ST_JUDGE: begin
            if (accept && span_ok) begin
              state       <= ST_IDLE;
              busy_o      <= 1'b0;
              done_o      <= 1'b1;
              samp_en_o   <= 1'b0;
              phase_sel_o <= tap;
            end else if (accept || unit_code_o == LAST_CODE) begin
              state       <= ST_IDLE;
              busy_o      <= 1'b0;
              error_o     <= 1'b1;
              line_en_o   <= 1'b0;
              samp_en_o   <= 1'b0;
              unit_code_o <= '0;
              phase_sel_o <= '0;
            end else begin
              state       <= ST_SETTLE;
              unit_code_o <= unit_code_o + 1'b1;
              phase_sel_o <= PROBE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dly_cal_ctrl_chk.sv
module dly_cal_ctrl_chk #(
  parameter int LEN_W     = 12,
  parameter int CODE_W    = 7,
  parameter int SEL_W     = 4,
  parameter int PROBE_SEL = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              disable_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              line_en_o,
  input logic              samp_en_o,
  input logic [CODE_W-1:0] unit_code_o,
  input logic [SEL_W-1:0]  phase_sel_o
);
  localparam logic [SEL_W-1:0] PROBE   = SEL_W'(PROBE_SEL);
  localparam logic [SEL_W-1:0] TAP_MAX = SEL_W'((LEN_W - 2) / 2 + 1);

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !disable_i) |=>
      (busy_o && line_en_o && samp_en_o && unit_code_o == '0 && phase_sel_o == PROBE));

  assert_probe_R3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (phase_sel_o == PROBE && samp_en_o && line_en_o));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !disable_i) |=>
      (!busy_o || unit_code_o == $past(unit_code_o) ||
       unit_code_o == CODE_W'($past(unit_code_o) + 1'b1)));

  assert_tap_range_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (phase_sel_o >= SEL_W'(1) && phase_sel_o <= TAP_MAX));

  assert_done_state_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (line_en_o && !samp_en_o && !busy_o && !error_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_error_clear_R7: assert property (@(posedge clk) disable iff (rst)
    error_o |-> (!line_en_o && !samp_en_o && unit_code_o == '0 &&
                 phase_sel_o == '0 && !busy_o));

  assert_error_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    error_o |=> !error_o);

  assert_disable_R9: assert property (@(posedge clk) disable iff (rst)
    disable_i |=> (!busy_o && !line_en_o && !samp_en_o && !done_o && !error_o));
endmodule

bind dly_cal_ctrl dly_cal_ctrl_chk #(
  .LEN_W(LEN_W), .CODE_W(CODE_W), .SEL_W(SEL_W), .PROBE_SEL(PROBE_SEL)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .disable_i(disable_i),
  .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
  .line_en_o(line_en_o), .samp_en_o(samp_en_o),
  .unit_code_o(unit_code_o), .phase_sel_o(phase_sel_o)
);

// File: tb/dly_cal_ctrl_tb.sv
module dly_cal_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S          = 4;
  localparam int MAXT       = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        disable_i = 1'b0;
  logic [11:0] len_vec_i;
  logic        len_valid_i;
  logic        busy_o, done_o, error_o, line_en_o, samp_en_o;
  logic [6:0]  unit_code_o;
  logic [3:0]  phase_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  int done_seen = 0;
  int err_seen = 0;

  // behavioural delay line model
  int          acc_code = 999;
  logic [11:0] acc_vec  = '0;
  int          inv_code = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_cal_ctrl #(.SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .disable_i(disable_i),
    .len_vec_i(len_vec_i), .len_valid_i(len_valid_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .line_en_o(line_en_o), .samp_en_o(samp_en_o),
    .unit_code_o(unit_code_o), .phase_sel_o(phase_sel_o)
  );

  always_comb begin
    if (!samp_en_o)                         len_vec_i = 12'h000;
    else if (int'(unit_code_o) == acc_code) len_vec_i = acc_vec;
    else if (int'(unit_code_o) == inv_code) len_vec_i = 12'h0F0;
    else if (unit_code_o[0])                len_vec_i = 12'hC00;
    else                                    len_vec_i = 12'h000;
    len_valid_i = samp_en_o && (int'(unit_code_o) != inv_code);
  end

  always @(negedge clk) begin
    if (done_o)  done_seen++;
    if (error_o) err_seen++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk_idle_zero(input string req);
    chk(busy_o == 0,      req, "busy",      busy_o, 0);
    chk(line_en_o == 0,   req, "line_en",   line_en_o, 0);
    chk(samp_en_o == 0,   req, "samp_en",   samp_en_o, 0);
    chk(unit_code_o == 0, req, "unit_code", unit_code_o, 0);
    chk(phase_sel_o == 0, req, "phase_sel", phase_sel_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_idle_zero("R1");
    chk(done_o == 0 && error_o == 0, "R1", "pulses", done_o + error_o, 0);
  endtask

  // code: accepted code (>=MAXT means none); ok: expect done; inject: start while busy
  task automatic t_run(input int code, input logic [11:0] vec, input int inv,
                       input bit ok, input int exp_sel, input bit inject);
    int ev;
    acc_code = code; acc_vec = vec; inv_code = inv;
    ev = ((code >= MAXT ? MAXT - 1 : code) + 1) * (S + 1);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o && line_en_o && samp_en_o, "R2", "enables after start",
        {busy_o, line_en_o, samp_en_o}, 7);
    chk(unit_code_o == 0 && phase_sel_o == 12, "R2", "first setting",
        phase_sel_o, 12);
    for (int i = 1; i < ev; i++) begin
      @(negedge clk) start_i = (inject && i == S + 3);
    end
    start_i = 1'b0;
    chk(busy_o && !done_o && !error_o, "R3", "still busy before verdict", busy_o, 1);
    if (code < MAXT)
      chk(unit_code_o == code, "R3", "code at verdict", unit_code_o, code);
    @(negedge clk);
    if (ok) begin
      chk(done_o && !error_o, inject ? "R10" : "R6", "done pulse", done_o, 1);
      chk(phase_sel_o == exp_sel, "R5", "phase tap", phase_sel_o, exp_sel);
      chk(line_en_o && !samp_en_o && !busy_o, "R6", "line on, sampler off",
          {line_en_o, samp_en_o, busy_o}, 4);
      chk(unit_code_o == code, "R6", "code held", unit_code_o, code);
    end else begin
      chk(error_o && !done_o, code >= MAXT ? "R8" : "R7", "error pulse", error_o, 1);
      chk_idle_zero(code >= MAXT ? "R8" : "R7");
    end
    @(negedge clk);
    chk(!done_o && !error_o, "R6", "pulse is one cycle", done_o + error_o, 0);
  endtask

  task automatic t_disable_mid();
    int d0, e0;
    acc_code = 2; acc_vec = 12'h0F0; inv_code = -1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (3) @(negedge clk);
    d0 = done_seen; e0 = err_seen;
    start_i = 1'b1; disable_i = 1'b1;
    @(negedge clk) start_i = 1'b0; disable_i = 1'b0;
    chk_idle_zero("R9");
    repeat (4 * (S + 1)) @(negedge clk);
    chk(done_seen == d0 && err_seen == e0, "R9", "no pulse after abort",
        done_seen - d0 + err_seen - e0, 0);
    chk(line_en_o == 0, "R9", "line stays off", line_en_o, 0);
  endtask

  task automatic t_disable_after_done();
    @(negedge clk) disable_i = 1'b1;
    @(negedge clk) disable_i = 1'b0;
    chk_idle_zero("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle_zero("R1");
    rst = 1'b0;
    t_reset();
    t_run(0, 12'h0F0, -1, 1'b1, 4, 1'b0);   // R5 N=7
    t_run(5, 12'h7FF, -1, 1'b1, 6, 1'b0);   // R3/R4 C00 and 000 rejected, N=10
    t_run(2, 12'h002, -1, 1'b1, 1, 1'b0);   // R5 N=1
    t_run(4, 12'h00C,  1, 1'b1, 2, 1'b0);   // R4 valid low at code 1 rejected
    t_run(1, 12'h001, -1, 1'b0, 0, 1'b0);   // R7 only bit 0
    t_run(3, 12'h800, -1, 1'b0, 0, 1'b0);   // R7 only bit 11
    t_run(999, 12'h000, -1, 1'b0, 0, 1'b0); // R8 exhaust
    t_run(3, 12'h0F0, -1, 1'b1, 4, 1'b1);   // R10 restart ignored
    t_disable_after_done();
    t_disable_mid();
    report();
  end
endmodule